// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with Dual Output Routing

This block gathers 32 level-sensitive interrupt request lines into two CPU-facing interrupt outputs. Each request first passes through a two-flop synchroniser. A per-source enable mask decides which requests may reach an output. Software never writes the mask directly. It changes the mask through two registers: one sets mask bits, the other clears them. Mask bit 31 also works as a global gate: while it is clear, both outputs stay low.

A routing register sends each source to output 0 or to output 1. The block has a simple single-cycle register port. Writes take effect at the next clock edge, and read data comes back combinationally from the current state.

Software can read the raw synchronised levels and the masked status of each output. For output 0 the block also gives the index of the lowest-numbered pending source, with a valid flag. Because the requests are levels, a handler acknowledges a source by clearing its enable bit, or by removing the request at the source.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the enable mask and the routing register are zero. Both outputs are low, and the index-valid flag is low.
- R2: A read at offset 0x30 returns the synchronised request levels, whatever the mask and routing hold. An input change at the port shows up there after two rising clock edges.
- R3: A write to offset 0x34 sets each mask bit whose written bit is 1 and leaves the other bits alone. A read at 0x34 returns the current mask.
- R4: A write to offset 0x38 clears each mask bit whose written bit is 1 and leaves the other bits alone. Writing all ones disables every source. A read at 0x38 returns the current mask.
- R5: While mask bit 31 (the global gate) is 0, both status registers read zero and both outputs are low, whatever the other mask bits hold.
- R6: Routing register bit n at offset 0x20 picks the destination of source n: 0 means status at 0x00 and output 0, 1 means status at 0x04 and output 1. Writing 0 sends every source to output 0.
- R7: Status bit n is set exactly while source n is high, enabled and globally gated on, and routed to that status register. Clearing the enable bit, or dropping the request, removes it.
- R8: Each output goes high one clock edge after its status register becomes non-zero, and goes low one edge after it becomes zero.
- R9: The 5-bit index gives the lowest-numbered set bit of the output-0 status. The valid flag is high exactly when that status is non-zero, so a zero status read always comes with a low valid flag.
- R10: Writes to offsets 0x00, 0x04 and 0x30 change neither the mask nor the routing register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32 | Level-sensitive request lines, bit n is source n |
| reg_we | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_out0 | output | 1 | Registered interrupt line for sources routed to 0 |
| irq_out1 | output | 1 | Registered interrupt line for sources routed to 1 |
| pend_idx | output | 5 | Lowest pending source index on output 0 |
| pend_valid | output | 1 | Output-0 status is non-zero |

## Verification
A corrupted mask or routing bit shows up at once in the status read-back at 0x00, 0x04, 0x34 or 0x38 in the cycle after the write that caused it. The interrupt lines follow one edge later. A fault in the lowest-index search shows on pend_idx in the same cycle as the status it disagrees with. A broken synchroniser depth shows as raw status arriving one edge early or late. The tests therefore sample the read-back, the index and the two lines at exact edge counts after each write or input change.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned IDX_W      = $clog2(REG_W);
    localparam int unsigned GATE_BIT   = REG_W - 1;
    localparam int unsigned OFS_W      = 8;

    localparam logic [OFS_W-1:0] OFS_STAT0 = 8'h00;
    localparam logic [OFS_W-1:0] OFS_STAT1 = 8'h04;
    localparam logic [OFS_W-1:0] OFS_ROUTE = 8'h20;
    localparam logic [OFS_W-1:0] OFS_RAW   = 8'h30;
    localparam logic [OFS_W-1:0] OFS_ENSET = 8'h34;
    localparam logic [OFS_W-1:0] OFS_ENCLR = 8'h38;

    typedef logic [REG_W-1:0] word_t;

    typedef struct packed {
        word_t mask;
        word_t route;
    } cfg_t;

    typedef struct packed {
        logic line0;
        logic line1;
    } lines_t;
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_ofs,
    input  word_t            wr_data,
    output word_t            mask,
    output word_t            route
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (wr_ofs)
                OFS_ENSET: cfg_d.mask  = cfg_q.mask | wr_data;
                OFS_ENCLR: cfg_d.mask  = cfg_q.mask & ~wr_data;
                OFS_ROUTE: cfg_d.route = wr_data;
                default:   cfg_d       = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mask  = cfg_q.mask;
    assign route = cfg_q.route;
endmodule

// File: rtl/irqagg_route.sv
module irqagg_route
    import irqagg_pkg::*;
(
    input  word_t            raw,
    input  word_t            mask,
    input  word_t            route,
    output word_t            stat0,
    output word_t            stat1,
    output logic [IDX_W-1:0] low_idx,
    output logic             low_valid
);
    word_t live;

    always_comb begin
        live  = mask[GATE_BIT] ? (raw & mask) : '0;
        stat0 = live & ~route;
        stat1 = live & route;
    end

    // lowest set bit of stat0, scanned from the top down so the lowest wins
    always_comb begin
        low_idx   = '0;
        low_valid = 1'b0;
        for (int i = REG_W - 1; i >= 0; i--) begin
            if (stat0[i]) begin
                low_idx   = IDX_W'(i);
                low_valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] irq_in,
    input  logic             reg_we,
    input  logic [OFS_W-1:0] reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_out0,
    output logic             irq_out1,
    output logic [IDX_W-1:0] pend_idx,
    output logic             pend_valid
);
    word_t  raw_sync, mask_q, route_q, stat0, stat1;
    lines_t lines_d, lines_q;

    irqagg_sync #(.WIDTH(REG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(irq_in), .sync_out(raw_sync)
    );

    irqagg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_ofs(reg_addr),
        .wr_data(reg_wdata), .mask(mask_q), .route(route_q)
    );

    irqagg_route u_route (
        .raw(raw_sync), .mask(mask_q), .route(route_q),
        .stat0(stat0), .stat1(stat1),
        .low_idx(pend_idx), .low_valid(pend_valid)
    );

    always_comb begin
        lines_d.line0 = |stat0;
        lines_d.line1 = |stat1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lines_q <= '0;
        else        lines_q <= lines_d;
    end

    assign irq_out0 = lines_q.line0;
    assign irq_out1 = lines_q.line1;

    always_comb begin
        unique case (reg_addr)
            OFS_STAT0:            reg_rdata = stat0;
            OFS_STAT1:            reg_rdata = stat1;
            OFS_ROUTE:            reg_rdata = route_q;
            OFS_RAW:              reg_rdata = raw_sync;
            OFS_ENSET, OFS_ENCLR: reg_rdata = mask_q;
            default:              reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
    import irqagg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [OFS_W-1:0] reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             irq_out0,
    input logic             irq_out1,
    input logic [IDX_W-1:0] pend_idx,
    input logic             pend_valid,
    input logic [REG_W-1:0] mask_q,
    input logic [REG_W-1:0] route_q,
    input logic [REG_W-1:0] stat0
);
    assert_enset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_ENSET) |=> (mask_q == ($past(mask_q) | $past(reg_wdata))));

    assert_enclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_ENCLR) |=> (mask_q == ($past(mask_q) & ~$past(reg_wdata))));

    assert_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q[GATE_BIT] |=> (!irq_out0 && !irq_out1));

    assert_route1_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_STAT1) |-> ((reg_rdata & ~route_q) == '0));

    assert_line_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |=> irq_out0);

    assert_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (stat0[pend_idx] && ((stat0 & ((32'h1 << pend_idx) - 32'h1)) == '0)));

    assert_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_STAT0 && reg_rdata == '0) |-> !pend_valid);

    assert_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr == OFS_STAT0 || reg_addr == OFS_STAT1 || reg_addr == OFS_RAW))
        |=> ($stable(mask_q) && $stable(route_q)));
endmodule

bind irq_aggregator irqagg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out0(irq_out0),
    .irq_out1(irq_out1), .pend_idx(pend_idx), .pend_valid(pend_valid),
    .mask_q(mask_q), .route_q(route_q), .stat0(stat0)
);

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out0, irq_out1, pend_valid;
    logic [4:0]  pend_idx;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_aggregator u_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out0(irq_out0), .irq_out1(irq_out1),
        .pend_idx(pend_idx), .pend_valid(pend_valid)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic drive(logic [31:0] v, int edges);
        @(negedge clk);
        irq_in = v;
        repeat (edges) @(negedge clk);
    endtask

    function automatic logic [5:0] lowest(logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return 6'(i) | 6'h20;
        return 6'h0;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h34, d); check("R1 mask", d, 32'h0);
        rd(8'h20, d); check("R1 route", d, 32'h0);
        check("R1 out0", 32'(irq_out0), 32'h0);
        check("R1 out1", 32'(irq_out1), 32'h0);
        check("R1 valid", 32'(pend_valid), 32'h0);
    endtask

    task automatic t_raw();
        logic [31:0] d;
        drive(32'hA5A5_0F0F, 1);
        rd(8'h30, d); check("R2 raw after one edge", d, 32'h0);
        @(negedge clk);
        rd(8'h30, d); check("R2 raw after two edges", d, 32'hA5A5_0F0F);
        rd(8'h00, d); check("R9 masked status zero", d, 32'h0);
        check("R9 spurious valid low", 32'(pend_valid), 32'h0);
        drive(32'h0, 2);
    endtask

    task automatic t_set_clear();
        logic [31:0] d;
        wr(8'h34, 32'h0000_00F0); rd(8'h34, d); check("R3 set", d, 32'h0000_00F0);
        wr(8'h34, 32'h0000_000F); rd(8'h34, d); check("R3 set keeps", d, 32'h0000_00FF);
        wr(8'h38, 32'h0000_0030); rd(8'h38, d); check("R4 clear", d, 32'h0000_00CF);
        wr(8'h38, 32'hFFFF_FFFF); rd(8'h34, d); check("R4 clear all", d, 32'h0);
    endtask

    task automatic t_gate();
        logic [31:0] d;
        wr(8'h34, 32'h0000_0FF0);
        drive(32'h0000_0110, 3);
        rd(8'h00, d); check("R5 gate off status", d, 32'h0);
        check("R5 gate off out0", 32'(irq_out0), 32'h0);
        wr(8'h34, 32'h8000_0000);
        rd(8'h00, d); check("R7 status", d, 32'h0000_0110);
        check("R9 index", 32'(pend_idx), 32'd4);
        check("R9 valid", 32'(pend_valid), 32'h1);
        @(negedge clk);
        check("R8 out0 rises", 32'(irq_out0), 32'h1);
    endtask

    task automatic t_route();
        logic [31:0] d;
        wr(8'h20, 32'h0000_0010);
        rd(8'h00, d); check("R6 status0", d, 32'h0000_0100);
        rd(8'h04, d); check("R6 status1", d, 32'h0000_0010);
        check("R9 index after route", 32'(pend_idx), 32'd8);
        @(negedge clk);
        check("R6 out1", 32'(irq_out1), 32'h1);
        check("R6 out0", 32'(irq_out0), 32'h1);
        wr(8'h20, 32'h0000_0110);
        rd(8'h00, d); check("R6 status0 empty", d, 32'h0);
        check("R9 valid low", 32'(pend_valid), 32'h0);
        @(negedge clk);
        check("R8 out0 falls", 32'(irq_out0), 32'h0);
        wr(8'h20, 32'h0);
        rd(8'h04, d); check("R6 route zero", d, 32'h0);
        @(negedge clk);
        check("R6 out1 low", 32'(irq_out1), 32'h0);
    endtask

    task automatic t_ack();
        logic [31:0] d;
        wr(8'h38, 32'h0000_0010);
        rd(8'h00, d); check("R7 acked by clear", d, 32'h0000_0100);
        check("R9 index moves", 32'(pend_idx), 32'd8);
        drive(32'h0, 1);
        rd(8'h00, d); check("R7 still synced", d, 32'h0000_0100);
        @(negedge clk);
        rd(8'h00, d); check("R7 request dropped", d, 32'h0);
        @(negedge clk);
        check("R8 out0 low", 32'(irq_out0), 32'h0);
    endtask

    task automatic t_scan();
        logic [31:0] d;
        logic [31:0] pats [5] = '{32'h8000_0000, 32'h0000_0001, 32'h0F00_0000,
                                  32'h4000_2000, 32'hFFFF_FFFF};
        wr(8'h34, 32'hFFFF_FFFF);
        foreach (pats[k]) begin
            logic [5:0] e;
            drive(pats[k], 2);
            e = lowest(pats[k]);
            rd(8'h00, d); check("R7 scan status", d, pats[k]);
            check("R9 scan valid", 32'(pend_valid), 32'(e[5]));
            check("R9 scan index", 32'(pend_idx), 32'(e[4:0]));
        end
        wr(8'h38, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R4 all off out0", 32'(irq_out0), 32'h0);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        wr(8'h34, 32'h0000_1234);
        wr(8'h20, 32'h0000_5678);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h30, 32'h0);
        rd(8'h34, d); check("R10 mask kept", d, 32'h0000_1234);
        rd(8'h20, d); check("R10 route kept", d, 32'h0000_5678);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_raw();
        t_set_clear();
        t_gate();
        t_route();
        t_ack();
        t_scan();
        t_ignored();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule